// File: doc/BRIEF.md
# Soft-Ramp Digital Volume Control

This block attenuates two channels of signed 24-bit audio samples. Each channel has its own 8-bit attenuation code, in half-decibel steps, and its own mute request. One 2-bit transfer mode, shared by both channels, sets how a channel moves from its current gain to a new one. It can jump at once. It can wait for the channel's signal to cross zero. It can walk there one half-decibel step at a time. Or it can walk there in steps that each wait for a zero crossing. A mute request is treated as a move to the code that gives silence, so it follows the same transfer mode.

Each channel is built around a small controller with three states. `ST_SETTLED` means the effective code equals the target. `ST_HOLD_ZC` means a whole change is waiting for a zero crossing. `ST_STEPPING` means a ramp is in progress. The transitions are as follows:

- Any state goes to `ST_SETTLED` on a sample after which the effective code equals the target.
- It goes to `ST_HOLD_ZC` when a mismatch remains under the zero-cross mode.
- It goes to `ST_STEPPING` when a mismatch remains under either ramp mode.

A channel's mute-active flag rises only once that channel is settled at silence under a mute request. The external mute pins drive a polarity that is sampled from the pins themselves on the first clock after reset is released.

Top module: `soft_vol_ctrl`

## Requirements
- R1: The effective code c sets coefficient k = round(32768 * 2^(-(c mod 12)/12)) >> floor(c/12). Each output is (x*k + 16384) >>> 15. So code 0 passes samples unchanged, code 6 is about -3 dB, and every code from 192 up, including 255, gives silence.
- R2: An output sample and `out_valid` appear one clock after the `smp_valid` cycle. The gain used is the channel's effective code after that sample's own update.
- R3: With mode 00, the effective code takes the target on the current sample.
- R4: With mode 01, the target is taken on a zero-crossing sample. A zero crossing is a sample equal to 0, or a sample whose sign differs from the previous sample of the same channel. The sign held at reset is positive.
- R5: With mode 01 or 11, a change that has waited ZC_LIMIT consecutive samples without a crossing is applied on the ZC_LIMIT-th sample.
- R6: With mode 10, the effective code moves one step toward the target on every STEP_SAMPLES-th sample while a mismatch remains.
- R7: With mode 11, a step is taken only when STEP_SAMPLES samples have elapsed and the current sample is a zero crossing, or the ZC_LIMIT wait has expired.
- R8: Zero crossings are detected per channel. A crossing on one channel never applies a pending change on the other.
- R9: `mute_req` for a channel makes its target 255, using the same mode as a volume change.
- R10: `mute_active` for a channel is 1 only after a sample that leaves the channel settled at code 255 while its mute request is set.
- R11: On the first clock after reset release, `mute_sense` is captured as the active level and then kept. After that, `mute_drive_en` is 1 and each `mute_drive` bit equals the active level when that channel's mute is active, and its inverse otherwise.
- R12: During reset, `smp_out` is 0, `out_valid` is 0, `mute_drive_en` is 0, and both effective codes are 0.
- R13: Without `smp_valid`, the effective codes and `smp_out` do not change, whatever the code inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One-cycle strobe: a new sample for every channel |
| smp_in | input | NCH*DW | Signed samples; channel 0 in the low bits |
| atten_code | input | NCH*CW | Attenuation codes in 0.5 dB steps; channel 0 in the low bits |
| mute_req | input | NCH | Per-channel mute request |
| xfer_mode | input | 2 | 00 immediate, 01 zero cross, 10 ramp, 11 ramp on zero crossings |
| smp_out | output | NCH*DW | Attenuated samples |
| out_valid | output | 1 | `smp_out` updated this cycle |
| mute_active | output | NCH | Channel settled in silence under mute |
| mute_sense | input | NCH | Level seen on the mute pins, sampled after reset |
| mute_drive | output | NCH | Mute pin level to drive |
| mute_drive_en | output | 1 | Mute pins driven |

## Verification
The bench builds the block with STEP_SAMPLES = 4 and ZC_LIMIT = 16. The timeout and every ramp step can then be reached within a few dozen samples. A full mute ramp from a high code is also reachable. Mode 00 is swept over all 256 codes on both channels, using full-scale positive, full-scale negative and small samples. This exercises every coefficient, the octave shift down to silence, and rounding of negative products. The remaining modes run fixed sign patterns, so crossings, step deadlines and the timeout each land on a known sample.

// File: rtl/svc_pkg.sv
package svc_pkg;

    typedef enum logic [1:0] {
        ST_SETTLED  = 2'd0,
        ST_HOLD_ZC  = 2'd1,
        ST_STEPPING = 2'd2
    } ch_state_t;

    typedef enum logic [1:0] {
        XF_IMMEDIATE  = 2'b00,
        XF_ZERO_CROSS = 2'b01,
        XF_RAMP       = 2'b10,
        XF_RAMP_ZC    = 2'b11
    } xfer_t;

    localparam int COEF_W    = 16;
    localparam int COEF_FRAC = 15;

    // One octave (12 half-dB steps = 6.02 dB) of Q1.15 gains.
    function automatic logic [COEF_W-1:0] semitone_base(input logic [3:0] k);
        logic [COEF_W-1:0] v;
        case (k)
            4'd0:    v = 16'd32768;
            4'd1:    v = 16'd30929;
            4'd2:    v = 16'd29193;
            4'd3:    v = 16'd27554;
            4'd4:    v = 16'd26008;
            4'd5:    v = 16'd24548;
            4'd6:    v = 16'd23170;
            4'd7:    v = 16'd21870;
            4'd8:    v = 16'd20643;
            4'd9:    v = 16'd19484;
            4'd10:   v = 16'd18390;
            4'd11:   v = 16'd17358;
            default: v = 16'd0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/svc_gain_lut.sv
module svc_gain_lut #(
    parameter int CW = 8
) (
    input  logic [CW-1:0]              code,
    output logic [svc_pkg::COEF_W-1:0] coef
);
    logic [CW-1:0] octave;
    logic [CW-1:0] semis;

    always_comb begin
        octave = code / CW'(12);
        semis  = code % CW'(12);
        coef   = svc_pkg::semitone_base(semis[3:0]) >> octave;
    end
endmodule

// File: rtl/svc_scale.sv
module svc_scale #(
    parameter int DW = 24
) (
    input  logic [DW-1:0]              x,
    input  logic [svc_pkg::COEF_W-1:0] coef,
    output logic [DW-1:0]              y
);
    localparam int PW = DW + svc_pkg::COEF_W + 1;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;

    always_comb begin
        prod = $signed(x) * $signed({1'b0, coef});
        rnd  = prod + $signed({{(PW-svc_pkg::COEF_FRAC){1'b0}}, 15'h4000});
        y    = rnd[svc_pkg::COEF_FRAC +: DW];
    end
endmodule

// File: rtl/svc_channel.sv
module svc_channel
    import svc_pkg::*;
#(
    parameter int DW    = 24,
    parameter int CW    = 8,
    parameter int STEP  = 8,
    parameter int ZCL   = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [DW-1:0] x,
    input  logic [CW-1:0] code,
    input  logic          mute,
    input  logic [1:0]    mode,
    output logic [CW-1:0] eff_code,
    output logic          mute_act
);
    localparam int RW = (STEP > 1) ? $clog2(STEP) : 1;
    localparam int ZW = (ZCL > 1) ? $clog2(ZCL) : 1;
    localparam logic [CW-1:0] CODE_MAX = '1;
    localparam logic [RW-1:0] DUE_AT   = RW'(STEP - 1);
    localparam logic [ZW-1:0] ZC_LAST  = ZW'(ZCL - 1);

    ch_state_t     state, st_nxt;
    xfer_t         mode_e;
    logic [CW-1:0] cur, nxt, target, step_val;
    logic [RW-1:0] rcnt, rcnt_nxt;
    logic [ZW-1:0] zcw, zcw_nxt;
    logic          prev_neg, zc, zc_ok, due;

    assign mode_e   = xfer_t'(mode);
    assign target   = mute ? CODE_MAX : code;
    assign zc       = (x == '0) || (x[DW-1] != prev_neg);
    assign zc_ok    = zc || (zcw == ZC_LAST);
    assign due      = (rcnt == DUE_AT);
    assign step_val = (target > cur) ? cur + 1'b1 : cur - 1'b1;
    assign eff_code = nxt;

    always_comb begin
        nxt = cur;
        unique case (mode_e)
            XF_IMMEDIATE:  nxt = target;
            XF_ZERO_CROSS: if (zc_ok) nxt = target;
            XF_RAMP:       if (due && target != cur) nxt = step_val;
            XF_RAMP_ZC:    if (due && zc_ok && target != cur) nxt = step_val;
            default:       nxt = cur;
        endcase

        if (target == cur || nxt != cur) begin
            rcnt_nxt = '0;
            zcw_nxt  = '0;
        end else begin
            rcnt_nxt = due ? rcnt : rcnt + 1'b1;
            zcw_nxt  = (mode[0] && zcw != ZC_LAST) ? zcw + 1'b1 : zcw;
        end

        if (nxt == target)  st_nxt = ST_SETTLED;
        else if (mode[1])   st_nxt = ST_STEPPING;
        else                st_nxt = ST_HOLD_ZC;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_SETTLED;
            cur      <= '0;
            rcnt     <= '0;
            zcw      <= '0;
            prev_neg <= 1'b0;
        end else if (smp_valid) begin
            state    <= st_nxt;
            cur      <= nxt;
            rcnt     <= rcnt_nxt;
            zcw      <= zcw_nxt;
            prev_neg <= x[DW-1];
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n)         mute_act <= 1'b0;
        else if (smp_valid) mute_act <= mute && (st_nxt == ST_SETTLED);
    end

    assert_immediate_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && mode == 2'b00) |=> (cur == $past(target)));

    assert_zc_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && mode == 2'b01 && !zc && zcw != ZC_LAST) |=> $stable(cur));

    assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && mode[1]) |=> (cur == $past(cur) || cur == CW'($past(cur) + 1'b1)
                                    || cur == CW'($past(cur) - 1'b1)));

    assert_mute_settled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mute_act |-> (cur == CODE_MAX && state == ST_SETTLED));

    assert_hold_between_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(cur));
endmodule

// File: rtl/svc_mute_pin.sv
module svc_mute_pin #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] sense,
    input  logic [NCH-1:0] active,
    output logic [NCH-1:0] drive,
    output logic           drive_en
);
    logic [NCH-1:0] pol_q;
    logic           taken;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= '0;
            taken <= 1'b0;
        end else if (!taken) begin
            pol_q <= sense;
            taken <= 1'b1;
        end
    end

    assign drive    = pol_q ~^ active;
    assign drive_en = taken;

    assert_polarity_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> $stable(pol_q));
endmodule

// File: rtl/soft_vol_ctrl.sv
module soft_vol_ctrl #(
    parameter int NCH          = 2,
    parameter int DW           = 24,
    parameter int CW           = 8,
    parameter int STEP_SAMPLES = 8,
    parameter int ZC_LIMIT     = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [NCH*DW-1:0] smp_in,
    input  logic [NCH*CW-1:0] atten_code,
    input  logic [NCH-1:0]    mute_req,
    input  logic [1:0]        xfer_mode,
    output logic [NCH*DW-1:0] smp_out,
    output logic              out_valid,
    output logic [NCH-1:0]    mute_active,
    input  logic [NCH-1:0]    mute_sense,
    output logic [NCH-1:0]    mute_drive,
    output logic              mute_drive_en
);
    logic [NCH*DW-1:0] y_all;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [CW-1:0]              eff;
        logic [svc_pkg::COEF_W-1:0] coef;

        svc_channel #(.DW(DW), .CW(CW), .STEP(STEP_SAMPLES), .ZCL(ZC_LIMIT)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_valid (smp_valid),
            .x         (smp_in[ch*DW +: DW]),
            .code      (atten_code[ch*CW +: CW]),
            .mute      (mute_req[ch]),
            .mode      (xfer_mode),
            .eff_code  (eff),
            .mute_act  (mute_active[ch])
        );

        svc_gain_lut #(.CW(CW)) u_lut (
            .code (eff),
            .coef (coef)
        );

        svc_scale #(.DW(DW)) u_scale (
            .x    (smp_in[ch*DW +: DW]),
            .coef (coef),
            .y    (y_all[ch*DW +: DW])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_out   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= smp_valid;
            if (smp_valid) smp_out <= y_all;
        end
    end

    svc_mute_pin #(.NCH(NCH)) u_mute_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .sense    (mute_sense),
        .active   (mute_active),
        .drive    (mute_drive),
        .drive_en (mute_drive_en)
    );

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> out_valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !out_valid);

    assert_out_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(smp_out));
endmodule

// File: tb/test_soft_vol_ctrl.sv
module test_soft_vol_ctrl;
    localparam int NCH = 2, DW = 24, CW = 8, STEP = 4, ZCL = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic [NCH*DW-1:0] smp_in = '0;
    logic [NCH*CW-1:0] atten_code = '0;
    logic [NCH-1:0] mute_req = '0;
    logic [1:0] xfer_mode = 2'b00;
    logic [NCH*DW-1:0] smp_out;
    logic out_valid;
    logic [NCH-1:0] mute_active;
    logic [NCH-1:0] mute_sense = 2'b01;
    logic [NCH-1:0] mute_drive;
    logic mute_drive_en;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    soft_vol_ctrl #(.NCH(NCH), .DW(DW), .CW(CW), .STEP_SAMPLES(STEP), .ZC_LIMIT(ZCL)) i_soft_vol_ctrl (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_in(smp_in),
        .atten_code(atten_code), .mute_req(mute_req), .xfer_mode(xfer_mode),
        .smp_out(smp_out), .out_valid(out_valid), .mute_active(mute_active),
        .mute_sense(mute_sense), .mute_drive(mute_drive), .mute_drive_en(mute_drive_en));

    function automatic int exp_coef(int c);
        real r;
        int b;
        r = 32768.0 * (2.0 ** (-(c % 12) / 12.0));
        b = $rtoi(r + 0.5);
        return (c / 12 >= 31) ? 0 : (b >> (c / 12));
    endfunction

    function automatic int exp_scale(int x, int c);
        longint p;
        p = longint'(x) * longint'(exp_coef(c)) + 64'sd16384;
        return int'(p >>> 15);
    endfunction

    function automatic int got_ch(int ch);
        return int'($signed(smp_out[ch*DW +: DW]));
    endfunction

    task automatic chk(string req, int got, int expv);
        n_tests++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, expv);
        end
    endtask

    task automatic send(int xl, int xr);
        @(negedge clk);
        smp_in = {xr[DW-1:0], xl[DW-1:0]};
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic set_codes(int cl, int cr);
        atten_code = {cr[CW-1:0], cl[CW-1:0]};
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int samp[4];
        int last_l, last_r;
        samp[0] = 8388607; samp[1] = -8388608; samp[2] = 12345; samp[3] = -1;

        repeat (4) @(negedge clk);
        chk("R12 out_valid in reset", int'(out_valid), 0);
        chk("R12 smp_out in reset", int'(smp_out != '0), 0);
        chk("R12 drive_en in reset", int'(mute_drive_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        mute_sense = 2'b10;   // must be ignored after capture
        @(negedge clk);
        chk("R11 drive_en after reset", int'(mute_drive_en), 1);
        chk("R11 inactive drive levels", int'(mute_drive), 2);

        // R1 R3 R2: immediate mode sweep over every code
        xfer_mode = 2'b00;
        last_l = 0; last_r = 0;
        for (int c = 0; c < 256; c++) begin
            for (int s = 0; s < 4; s++) begin
                int xr;
                xr = -(samp[s] / 2) - 3;
                set_codes(c, 255 - c);
                send(samp[s], xr);
                last_l = exp_scale(samp[s], c);
                last_r = exp_scale(xr, 255 - c);
                chk("R1 R3 left gain", got_ch(0), last_l);
                chk("R1 R3 right gain", got_ch(1), last_r);
            end
            chk("R2 out_valid", int'(out_valid), 1);
        end

        // R13: code changes without a sample have no effect
        set_codes(0, 0);
        repeat (3) @(negedge clk);
        chk("R13 left held", got_ch(0), last_l);
        chk("R13 right held", got_ch(1), last_r);
        chk("R13 no valid", int'(out_valid), 0);

        set_codes(10, 10);
        send(1000, 1000);
        chk("R3 settle 10", got_ch(0), exp_scale(1000, 10));

        // R5: zero-cross mode, no crossing -> timeout on the ZCL-th sample
        xfer_mode = 2'b01;
        set_codes(30, 30);
        for (int k = 1; k <= ZCL; k++) begin
            int ec;
            send(100000, 100000);
            ec = (k == ZCL) ? 30 : 10;
            chk("R5 timeout left", got_ch(0), exp_scale(100000, ec));
            chk("R5 timeout right", got_ch(1), exp_scale(100000, ec));
        end

        // R4 R8: crossing on one channel only
        set_codes(50, 50);
        send(200000, 200000);
        chk("R4 no crossing yet", got_ch(0), exp_scale(200000, 30));
        send(200000, 200000);
        chk("R4 no crossing yet", got_ch(1), exp_scale(200000, 30));
        send(-200000, 200000);
        chk("R4 left crossing applies", got_ch(0), exp_scale(-200000, 50));
        chk("R8 right unaffected", got_ch(1), exp_scale(200000, 30));
        send(-200000, -200000);
        chk("R8 right own crossing", got_ch(1), exp_scale(-200000, 50));
        chk("R4 left stays", got_ch(0), exp_scale(-200000, 50));
        send(300000, 300000);

        // R6: ramp mode, one step every STEP samples
        xfer_mode = 2'b10;
        set_codes(53, 47);
        for (int k = 1; k <= 16; k++) begin
            int st;
            st = (k / STEP > 3) ? 3 : k / STEP;
            send(300000, 300000);
            chk("R6 ramp up left", got_ch(0), exp_scale(300000, 50 + st));
            chk("R6 ramp down right", got_ch(1), exp_scale(300000, 50 - st));
        end

        // R7: ramp on zero crossings
        xfer_mode = 2'b11;
        set_codes(54, 46);
        for (int k = 1; k <= ZCL; k++) begin
            int xl;
            int el, er;
            xl = (k == 3 || k == 4 || k == 5) ? -400000 : 400000;
            el = (k >= 6) ? 54 : 53;
            er = (k == ZCL) ? 46 : 47;
            send(xl, 400000);
            chk("R7 left step needs due and crossing", got_ch(0), exp_scale(xl, el));
            chk("R7 right step on timeout", got_ch(1), exp_scale(400000, er));
        end

        // R9 R10 R11: immediate mute on right channel
        xfer_mode = 2'b00;
        mute_req = 2'b10;
        send(500000, 500000);
        chk("R9 right silenced", got_ch(1), 0);
        chk("R9 left untouched", got_ch(0), exp_scale(500000, 54));
        chk("R10 right mute active", int'(mute_active), 2);
        chk("R11 right driven active", int'(mute_drive), 0);
        mute_req = 2'b00;
        send(500000, 500000);
        chk("R9 right restored", got_ch(1), exp_scale(500000, 46));
        chk("R10 mute cleared", int'(mute_active), 0);

        // R9 R10: ramped mute on left channel
        set_codes(250, 46);
        send(600000, 600000);
        xfer_mode = 2'b10;
        mute_req = 2'b01;
        for (int k = 1; k <= 5 * STEP; k++) begin
            int st;
            st = (k / STEP > 5) ? 5 : k / STEP;
            send(600000, 600000);
            chk("R9 mute ramp left", got_ch(0), exp_scale(600000, 250 + st));
            chk("R10 flag after ramp", int'(mute_active[0]), (k == 5 * STEP) ? 1 : 0);
        end
        chk("R11 left driven active", int'(mute_drive), 3);

        done = 1;
        finish_run();
    end
endmodule